// File: doc/BRIEF.md
# Asynchronous Read-Cycle Bus Master

This block runs one read transfer at a time on an asynchronous 32-bit bus. The requester hands over an address, a transfer size, an address-space code and a cache-inhibit request. The block then steps through six bus states of half a bus clock each: S0 to S5. Wait states go between S2 and S3 until the addressed device acknowledges.

The block runs from one internal clock at twice the bus rate. An internal phase flag marks which internal cycles start on a rising bus edge and which start on a falling one. Each internal cycle is one bus state.

The device answers on a two-line acknowledge pair, and the encoding on that pair also gives the device's port width. The two lines pass through a synchronizer before the sequencer looks at them. The cache-inhibit input is sampled on the rising edge that opens S4. The data word is captured on the falling edge that closes S4. Once the strobes have been negated in S5, a one-cycle completion pulse returns the word, the cache-inhibit result and the port width.

Top module: `async_rd_master`

## Requirements
- R1: While reset is held, all strobes, the address drive enable and the completion pulse are low. Within two cycles after reset is released, `req_ready_o` rises.
- R2: In the cycle after a request is taken (S0), the block drives the following:
  - `addr_drv_o` and `read_o` high;
  - address, size, space code and cache-inhibit-out equal to the request;
  - `cyc_start_o` high;
  - `opnd_start_o` high exactly when `req_opnd_i` was set;
  - both data-path strobes low.
- R3: One cycle after S0 (S1), `addr_stb_o` and `data_stb_o` rise together, and `cyc_start_o` and `opnd_start_o` are low.
- R4: `buf_en_o` is low in S1 and rises in the next cycle (S2). It is never high while `addr_stb_o` is low.
- R5: Counting S0 as cycle 0, suppose the acknowledge pair is first nonzero in cycle D (D ≥ 0) and stays so. Then the strobes stay high through cycle E+1, where E = 3 + 2·ceil(D/2). The completion pulse comes in cycle E+3. Wait states are therefore inserted in whole bus clocks, and the synchronizer adds two cycles of delay.
- R6: `done_cinh_o` reports the value that `cinh_in_i` had in cycle E, which is the state just before the rising edge that opens S4.
- R7: `done_data_o` reports the value that `data_i` had in cycle E+1 (S4).
- R8: In cycle E+2 (S5), `addr_stb_o`, `data_stb_o` and `buf_en_o` are low. `addr_drv_o` stays high, and the address, size and space code are unchanged from S0.
- R9: `done_port_o` encodes the acknowledge pair seen at termination:
  - both lines high (`2'b11`) gives `2'b10` (32-bit);
  - only line 1 high (`2'b10`) gives `2'b01` (16-bit);
  - only line 0 high (`2'b01`) gives `2'b00` (8-bit).
- R10: `done_o` is high for exactly one cycle. From S0 through the completion cycle, `req_ready_o` stays low and no new `cyc_start_o` appears, even while `req_valid_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this cycle when valid |
| req_addr_i | input | ADDR_W | Request address |
| req_size_i | input | SIZE_W | Request transfer size |
| req_space_i | input | SPACE_W | Request address-space code |
| req_cinh_i | input | 1 | Request cache-inhibit-out |
| req_opnd_i | input | 1 | Request is the first bus cycle of an operand |
| addr_o | output | ADDR_W | Bus address |
| xfer_size_o | output | SIZE_W | Bus transfer size |
| space_o | output | SPACE_W | Bus address-space code |
| cinh_out_o | output | 1 | Bus cache-inhibit-out |
| read_o | output | 1 | Read direction, high while the address is driven |
| addr_drv_o | output | 1 | Address and attributes valid (S0 to S5) |
| cyc_start_o | output | 1 | Cycle-start strobe (S0) |
| opnd_start_o | output | 1 | Operand-start strobe (S0 of an operand) |
| addr_stb_o | output | 1 | Address strobe |
| data_stb_o | output | 1 | Data strobe |
| buf_en_o | output | 1 | External data buffer enable |
| xfer_ack_i | input | 2 | Asynchronous acknowledge pair, active high |
| cinh_in_i | input | 1 | Cache-inhibit-in, synchronous |
| data_i | input | DATA_W | Read data bus |
| done_o | output | 1 | One-cycle completion pulse |
| done_data_o | output | DATA_W | Captured data word |
| done_cinh_o | output | 1 | Sampled cache-inhibit-in |
| done_port_o | output | 2 | Acknowledged port width |

## Verification
The in-design assertions check the following on every cycle:
- the strobe ordering: the address strobe rises only after the cycle-start strobe, and the buffer enable stays inside the address strobe;
- the address hold when the strobes fall;
- the single-cycle completion pulse;
- that S3 is entered only after a synchronized acknowledge;
- that the captured cache-inhibit and data registers hold still outside their sampling states.

Only the bench scenarios can show the exact wait-state count against the acknowledge delay, and that the sampling instants are exact. To do that, the bench offers the correct cache-inhibit and data values in a single cycle and corrupted values around it. The bench scenarios also cover the port-width decoding and the blocking of requests while a transfer is running.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_S0,
      ST_S1,
      ST_S2,
      ST_WA,
      ST_WB,
      ST_S3,
      ST_S4,
      ST_S5,
      ST_DONE
   } rd_state_e;

   typedef struct packed {
      logic addr_drv;
      logic cyc_start;
      logic addr_stb;
      logic data_stb;
      logic buf_en;
      logic done;
   } rd_strb_t;

   localparam logic [1:0] PORT_8  = 2'b00;
   localparam logic [1:0] PORT_16 = 2'b01;
   localparam logic [1:0] PORT_32 = 2'b10;

   // Strobe pattern belonging to each bus state
   function automatic rd_strb_t strobes_of(rd_state_e s);
      rd_strb_t r;
      r = '0;
      case (s)
         ST_S0: begin
            r.addr_drv  = 1'b1;
            r.cyc_start = 1'b1;
         end
         ST_S1: begin
            r.addr_drv = 1'b1;
            r.addr_stb = 1'b1;
            r.data_stb = 1'b1;
         end
         ST_S2, ST_WA, ST_WB, ST_S3, ST_S4: begin
            r.addr_drv = 1'b1;
            r.addr_stb = 1'b1;
            r.data_stb = 1'b1;
            r.buf_en   = 1'b1;
         end
         ST_S5:   r.addr_drv = 1'b1;
         ST_DONE: r.done = 1'b1;
         default: r = '0;
      endcase
      return r;
   endfunction

   // Port width from the acknowledge pair (bit 1 = line 1)
   function automatic logic [1:0] port_code(logic [1:0] ack);
      logic [1:0] p;
      case (ack)
         2'b11:   p = PORT_32;
         2'b10:   p = PORT_16;
         default: p = PORT_8;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/async_rd_sync.sv
module async_rd_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("async_rd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("async_rd_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[LAST];

endmodule

// File: rtl/async_rd_seq.sv
module async_rd_seq
   import async_rd_pkg::*;
#(
   parameter bit REG_STROBES = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid_i,
   input  logic     ack_any_i,
   output logic     req_ready_o,
   output logic     accept_o,
   output logic     decide_o,
   output logic     cinh_take_o,
   output logic     data_take_o,
   output rd_strb_t strb_o
);

   rd_state_e st_q, st_nxt;
   logic      fall_half_q;   // 1: this cycle begins on a falling bus edge

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fall_half_q <= 1'b1;
      else        fall_half_q <= ~fall_half_q;
   end

   assign req_ready_o = (st_q == ST_IDLE) && fall_half_q;
   assign accept_o    = req_ready_o && req_valid_i;
   assign decide_o    = ((st_q == ST_S2) || (st_q == ST_WB)) && ack_any_i;
   assign cinh_take_o = (st_q == ST_S3);
   assign data_take_o = (st_q == ST_S4);

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_IDLE: if (accept_o) st_nxt = ST_S0;
         ST_S0:   st_nxt = ST_S1;
         ST_S1:   st_nxt = ST_S2;
         ST_S2:   st_nxt = ack_any_i ? ST_S3 : ST_WA;
         ST_WA:   st_nxt = ST_WB;
         ST_WB:   st_nxt = ack_any_i ? ST_S3 : ST_WA;
         ST_S3:   st_nxt = ST_S4;
         ST_S4:   st_nxt = ST_S5;
         ST_S5:   st_nxt = ST_DONE;
         ST_DONE: st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nxt;
   end

   if (REG_STROBES) begin : g_reg_strb
      rd_strb_t strb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) strb_q <= '0;
         else        strb_q <= strobes_of(st_nxt);
      end
      assign strb_o = strb_q;
   end else begin : g_comb_strb
      assign strb_o = strobes_of(st_q);
   end

   // R3
   as_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_o.addr_stb) |-> $past(strb_o.cyc_start));

   // R4
   buf_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_o.buf_en |-> (strb_o.addr_stb && strb_o.data_stb));

   // R5
   ack_before_s3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_S3) |-> $past(ack_any_i));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_o.done |=> !strb_o.done);

   // R10
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> !(strb_o.addr_drv || strb_o.done));

endmodule

// File: rtl/async_rd_capture.sv
module async_rd_capture
   import async_rd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 2,
   parameter int SPACE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [SIZE_W-1:0]  req_size_i,
   input  logic [SPACE_W-1:0] req_space_i,
   input  logic               req_cinh_i,
   input  logic               req_opnd_i,
   input  logic               decide_i,
   input  logic [1:0]         ack_i,
   input  logic               cinh_take_i,
   input  logic               cinh_in_i,
   input  logic               data_take_i,
   input  logic [DATA_W-1:0]  data_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [SIZE_W-1:0]  size_o,
   output logic [SPACE_W-1:0] space_o,
   output logic               cinh_out_o,
   output logic               opnd_o,
   output logic [DATA_W-1:0]  data_o,
   output logic               cinh_res_o,
   output logic [1:0]         port_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o     <= '0;
         size_o     <= '0;
         space_o    <= '0;
         cinh_out_o <= 1'b0;
         opnd_o     <= 1'b0;
      end else if (accept_i) begin
         addr_o     <= req_addr_i;
         size_o     <= req_size_i;
         space_o    <= req_space_i;
         cinh_out_o <= req_cinh_i;
         opnd_o     <= req_opnd_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        port_o <= PORT_8;
      else if (decide_i) port_o <= port_code(ack_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cinh_res_o <= 1'b0;
      else if (cinh_take_i) cinh_res_o <= cinh_in_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           data_o <= '0;
      else if (data_take_i) data_o <= data_i;
   end

   // R9
   port_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decide_i |=> (port_o != 2'b11));

   // R6
   cinh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cinh_take_i |=> $stable(cinh_res_o));

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_take_i |=> $stable(data_o));

endmodule

// File: rtl/async_rd_master.sv
module async_rd_master
   import async_rd_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int SIZE_W      = 2,
   parameter int SPACE_W     = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_STROBES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [SIZE_W-1:0]  req_size_i,
   input  logic [SPACE_W-1:0] req_space_i,
   input  logic               req_cinh_i,
   input  logic               req_opnd_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [SIZE_W-1:0]  xfer_size_o,
   output logic [SPACE_W-1:0] space_o,
   output logic               cinh_out_o,
   output logic               read_o,
   output logic               addr_drv_o,
   output logic               cyc_start_o,
   output logic               opnd_start_o,
   output logic               addr_stb_o,
   output logic               data_stb_o,
   output logic               buf_en_o,
   input  logic [1:0]         xfer_ack_i,
   input  logic               cinh_in_i,
   input  logic [DATA_W-1:0]  data_i,
   output logic               done_o,
   output logic [DATA_W-1:0]  done_data_o,
   output logic               done_cinh_o,
   output logic [1:0]         done_port_o
);

   localparam int ACK_W = 2;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("async_rd_master: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("async_rd_master: ADDR_W too small");
   end

   logic [ACK_W-1:0] ack_sync;
   logic             accept, decide, cinh_take, data_take, opnd_q;
   rd_strb_t         strb;

   async_rd_sync #(.WIDTH(ACK_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (xfer_ack_i),
      .dout (ack_sync)
   );

   async_rd_seq #(.REG_STROBES(REG_STROBES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid_i(req_valid_i),
      .ack_any_i  (|ack_sync),
      .req_ready_o(req_ready_o),
      .accept_o   (accept),
      .decide_o   (decide),
      .cinh_take_o(cinh_take),
      .data_take_o(data_take),
      .strb_o     (strb)
   );

   async_rd_capture #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .SPACE_W(SPACE_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .req_addr_i (req_addr_i),
      .req_size_i (req_size_i),
      .req_space_i(req_space_i),
      .req_cinh_i (req_cinh_i),
      .req_opnd_i (req_opnd_i),
      .decide_i   (decide),
      .ack_i      (ack_sync),
      .cinh_take_i(cinh_take),
      .cinh_in_i  (cinh_in_i),
      .data_take_i(data_take),
      .data_i     (data_i),
      .addr_o     (addr_o),
      .size_o     (xfer_size_o),
      .space_o    (space_o),
      .cinh_out_o (cinh_out_o),
      .opnd_o     (opnd_q),
      .data_o     (done_data_o),
      .cinh_res_o (done_cinh_o),
      .port_o     (done_port_o)
   );

   assign addr_drv_o   = strb.addr_drv;
   assign read_o       = strb.addr_drv;
   assign cyc_start_o  = strb.cyc_start;
   assign opnd_start_o = strb.cyc_start & opnd_q;
   assign addr_stb_o   = strb.addr_stb;
   assign data_stb_o   = strb.data_stb;
   assign buf_en_o     = strb.buf_en;
   assign done_o       = strb.done;

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(addr_stb_o) |-> (addr_drv_o && $stable(addr_o) && $stable(space_o)
                              && $stable(xfer_size_o)));

   // R2
   start_with_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> (addr_drv_o && read_o && !addr_stb_o));

endmodule

// File: tb/async_rd_master_bench.sv
module async_rd_master_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_cinh, req_opnd;
   logic [31:0] req_addr;
   logic [1:0]  req_size;
   logic [2:0]  req_space;
   logic [31:0] addr;
   logic [1:0]  xsize;
   logic [2:0]  space;
   logic        cinh_out, rd, adrv, cstart, ostart, astb, dstb, buf_en;
   logic [1:0]  ack;
   logic        cinh_in;
   logic [31:0] data;
   logic        done, done_cinh;
   logic [31:0] done_data;
   logic [1:0]  done_port;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   async_rd_master u_async_rd_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_addr_i(req_addr), .req_size_i(req_size), .req_space_i(req_space),
      .req_cinh_i(req_cinh), .req_opnd_i(req_opnd),
      .addr_o(addr), .xfer_size_o(xsize), .space_o(space), .cinh_out_o(cinh_out),
      .read_o(rd), .addr_drv_o(adrv), .cyc_start_o(cstart), .opnd_start_o(ostart),
      .addr_stb_o(astb), .data_stb_o(dstb), .buf_en_o(buf_en),
      .xfer_ack_i(ack), .cinh_in_i(cinh_in), .data_i(data),
      .done_o(done), .done_data_o(done_data), .done_cinh_o(done_cinh),
      .done_port_o(done_port)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_term(input int d);
      return 3 + 2 * ((d + 1) / 2);
   endfunction

   function automatic logic [1:0] exp_port(input logic [1:0] pat);
      case (pat)
         2'b11:   return 2'b10;
         2'b10:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic [2:0] sp,
                       input logic ci, input logic op, input logic [1:0] pat,
                       input int d, input logic cv, input logic [31:0] w, input bit hold);
      int e;
      e = exp_term(d);
      @(negedge clk);
      req_addr = a; req_size = sz; req_space = sp; req_cinh = ci; req_opnd = op;
      req_valid = 1'b1; ack = 2'b00; data = ~w; cinh_in = ~cv;
      @(negedge clk);
      while (!cstart) @(negedge clk);
      if (!hold) req_valid = 1'b0;
      for (int n = 0; n <= e + 4; n++) begin
         if (n > 0) @(negedge clk);
         if (n == 0) begin
            // R2
            chk(adrv && rd, "R2 addr drive/read", {adrv, rd}, 2'b11);
            chk(addr == a, "R2 address", addr, a);
            chk(xsize == sz && space == sp && cinh_out == ci, "R2 attributes",
                {xsize, space, cinh_out}, {sz, sp, ci});
            chk(ostart == op, "R2 operand start", ostart, op);
            chk(!astb && !dstb, "R2 strobes low", {astb, dstb}, 0);
         end
         if (n == 1) begin
            // R3
            chk(astb && dstb, "R3 strobes rise", {astb, dstb}, 2'b11);
            chk(!cstart && !ostart, "R3 start negated", {cstart, ostart}, 0);
            // R4
            chk(!buf_en, "R4 buffer low in S1", buf_en, 0);
         end
         if (n == 2) chk(buf_en, "R4 buffer on in S2", buf_en, 1);
         if (n >= 1 && n <= e + 1) chk(astb, "R5 strobe held during wait", astb, 1);
         if (n <= e + 2) chk(!done, "R5 no early done", done, 0);
         if (n >= 1 && n <= e + 3) chk(!cstart, "R10 no restart while busy", cstart, 0);
         if (n <= e + 3) chk(!req_ready, "R10 ready low while busy", req_ready, 0);
         if (n == e + 2) begin
            // R8
            chk(!astb && !dstb && !buf_en, "R8 strobes negated",
                {astb, dstb, buf_en}, 0);
            chk(adrv && addr == a && space == sp && xsize == sz, "R8 address hold",
                addr, a);
         end
         if (n == e + 3) begin
            chk(done, "R5 done latency", done, 1);
            chk(done_data == w, "R7 data word", done_data, w);
            chk(done_cinh == cv, "R6 cache inhibit", done_cinh, cv);
            chk(done_port == exp_port(pat), "R9 port width", done_port, exp_port(pat));
         end
         if (n == e + 4) chk(!done, "R10 done single pulse", done, 0);
         ack     = (n >= d && n <= e + 1) ? pat : 2'b00;
         data    = (n == e + 1) ? w : ~w;
         cinh_in = (n == e) ? cv : ~cv;
         if (hold && n == e + 3) req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int seed_v;
      logic [1:0] pats [3];
      pats[0] = 2'b01; pats[1] = 2'b10; pats[2] = 2'b11;
      seed_v = $urandom(32'd7331);
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_space = '0;
      req_cinh = 1'b0; req_opnd = 1'b0; ack = '0; cinh_in = 1'b0; data = '0;
      repeat (3) @(negedge clk);
      // R1
      chk(!astb && !dstb && !buf_en && !cstart && !done && !adrv, "R1 reset quiet",
          {astb, dstb, buf_en, cstart, done, adrv}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      if (!req_ready) @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      repeat (6) @(negedge clk);
      chk(!cstart && !adrv, "R1 idle without request", {cstart, adrv}, 0);

      // directed corner cases
      xfer(32'h0000_0000, 2'b00, 3'd1, 1'b0, 1'b1, 2'b11, 0, 1'b1, 32'hDEAD_BEEF, 1'b0);
      xfer(32'hFFFF_FFFC, 2'b11, 3'd7, 1'b1, 1'b0, 2'b10, 1, 1'b0, 32'h1234_5678, 1'b1);
      xfer(32'h8000_0001, 2'b01, 3'd5, 1'b0, 1'b1, 2'b01, 2, 1'b1, 32'h0000_0000, 1'b1);
      xfer(32'h5555_AAAA, 2'b10, 3'd2, 1'b1, 1'b0, 2'b11, 15, 1'b0, 32'hFFFF_FFFF, 1'b0);

      // constrained random
      for (int i = 0; i < 40; i++) begin
         xfer($urandom, 2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
              pats[$urandom % 3], int'($urandom % 8), 1'($urandom), $urandom,
              1'($urandom));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule